// File: doc/BRIEF.md
# Basic Timer with Cascaded Watchdog

This block is a free-running timebase for a small controller. A prescaler divides the system clock by one of four powers of two, and each prescaler tick advances a timebase counter. When that counter wraps, it raises a sticky interrupt request. The same wrap also advances a short watchdog counter. If software does not clear the watchdog before that counter wraps, the block emits a one-clock system reset request.

The timebase counter has a second job. After the oscillator restarts from stop mode, a wakeup request clears the counter and the prescaler and drops the warm-up-done flag. The next counter wrap marks the oscillator as settled, and warm-up-done rises again so that the CPU clock can be released.

All pins are plain control and status levels or strobes. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bt_wdt_top`

## Requirements
- R1: `div_sel` picks the prescaler ratio 2^DIV_EXP[div_sel]. Code 0 selects DIV_EXP[0] and code 3 selects DIV_EXP[3], with defaults 5, 8, 10 and 12. After a clear, the first wrap comes exactly 2^(CNT_W+DIV_EXP[div_sel]) clock edges later.
- R2: A high `tb_clr` at a clock edge zeroes both the timebase counter and the prescaler. The next wrap then takes one full period, counted from that edge.
- R3: The timebase counter wraps when a tick arrives while the counter holds its all-ones value. On the edge where it wraps, `irq_req` becomes 1.
- R4: `irq_req` stays 1 until `irq_ack` is sampled high. It reads 0 after the following edge. If a wrap and an acknowledge arrive in the same cycle, the wrap wins.
- R5: The WD_W-bit watchdog counter advances by one on each timebase wrap. The wrap that takes it past its all-ones value (the 8th wrap with the default WD_W of 3) raises `sys_rst_req` on that edge.
- R6: A high `wd_clr` at an edge zeroes the watchdog counter and keeps `sys_rst_req` low for that edge. This holds even when a wrap that would have fired the reset arrives in the same cycle.
- R7: `sys_rst_req` is high for exactly one clock.
- R8: `warm_done` resets to 1. A high `wake_req` at an edge clears the timebase counter and the prescaler and drives `warm_done` to 0. `warm_done` returns to 1 on the edge of the next timebase wrap.
- R9: A clear (`tb_clr` or `wake_req`) wins over a tick in the same cycle. No wrap happens at that edge, and `irq_req` is not set.
- R10: While `rst_n` is low, the outputs read `irq_req`=0, `warm_done`=1 and `sys_rst_req`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Prescaler ratio code (see R1) |
| tb_clr | input | 1 | Strobe that clears the timebase counter and the prescaler |
| wd_clr | input | 1 | Strobe that clears the watchdog counter |
| irq_ack | input | 1 | Strobe that acknowledges the interrupt |
| wake_req | input | 1 | Stop-mode wakeup strobe that starts warm-up timing |
| irq_req | output | 1 | Sticky interrupt request raised by a timebase wrap |
| warm_done | output | 1 | High once the oscillator warm-up interval is complete |
| sys_rst_req | output | 1 | One-clock system reset request from the watchdog |

## Verification
The bench clears the timebase exactly on the edge where a wrap would land. A design that lets the tick win would raise the interrupt, or would shift every later wrap by one period.

It also clears the watchdog on the very edge of its reset-producing wrap. A design that orders those two the wrong way would still emit a reset pulse.

A wakeup is issued part-way through a count. A design that kept the old count would report warm-up done too early.

Every ratio code is timed edge by edge. This catches an off-by-one prescaler tap or a swapped code.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned NUM_DIV = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_DIV);
  typedef logic [SEL_W-1:0] div_sel_t;
endpackage

// File: rtl/bt_prescaler.sv
module bt_prescaler
  import bt_pkg::*;
#(
  parameter int unsigned DIV_EXP [NUM_DIV] = '{5, 8, 10, 12}
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  div_sel_t sel,
  output logic     tick
);
  localparam int unsigned MAX01 = (DIV_EXP[0] > DIV_EXP[1]) ? DIV_EXP[0] : DIV_EXP[1];
  localparam int unsigned MAX23 = (DIV_EXP[2] > DIV_EXP[3]) ? DIV_EXP[2] : DIV_EXP[3];
  localparam int unsigned PRE_W = (MAX01 > MAX23) ? MAX01 : MAX23;

  logic [PRE_W-1:0]   pre_q;
  logic [NUM_DIV-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  // one tap per ratio: high on the last clock of each 2^exp window
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    assign tap[i] = &pre_q[DIV_EXP[i]-1:0];
  end

  assign tick = tap[sel];
endmodule

// File: rtl/bt_timebase.sv
module bt_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic wrap
);
  logic [CNT_W-1:0] cnt_q;

  // a clear in the same cycle suppresses the wrap
  assign wrap = tick & (&cnt_q) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bt_watchdog.sv
module bt_watchdog #(
  parameter int unsigned WD_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [WD_W-1:0] cnt,
  output logic            fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (adv) begin
        cnt  <= cnt + 1'b1;
        fire <= &cnt;
      end
    end
  end
endmodule

// File: rtl/bt_wdt_top.sv
module bt_wdt_top
  import bt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WD_W  = 3,
  parameter int unsigned DIV_EXP [NUM_DIV] = '{5, 8, 10, 12}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       tb_clr,
  input  logic       wd_clr,
  input  logic       irq_ack,
  input  logic       wake_req,
  output logic       irq_req,
  output logic       warm_done,
  output logic       sys_rst_req
);
  logic            base_clr;
  logic            tick_w;
  logic            ovf_w;
  logic [WD_W-1:0] wd_cnt_w;

  assign base_clr = tb_clr | wake_req;

  bt_prescaler #(.DIV_EXP(DIV_EXP)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (base_clr),
    .sel  (div_sel),
    .tick (tick_w)
  );

  bt_timebase #(.CNT_W(CNT_W)) u_base (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (base_clr),
    .tick (tick_w),
    .wrap (ovf_w)
  );

  bt_watchdog #(.WD_W(WD_W)) u_wd (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wd_clr),
    .adv  (ovf_w),
    .cnt  (wd_cnt_w),
    .fire (sys_rst_req)
  );

  // interrupt flag: a new wrap wins over an acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_req <= 1'b0;
    else if (ovf_w)   irq_req <= 1'b1;
    else if (irq_ack) irq_req <= 1'b0;
  end

  // warm-up flag: a wakeup drops it, the next wrap raises it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        warm_done <= 1'b1;
    else if (wake_req) warm_done <= 1'b0;
    else if (ovf_w)    warm_done <= 1'b1;
  end
endmodule

// File: rtl/bt_wdt_chk.sv
module bt_wdt_chk #(
  parameter int unsigned WD_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tb_clr,
  input logic            wd_clr,
  input logic            irq_ack,
  input logic            wake_req,
  input logic            irq_req,
  input logic            warm_done,
  input logic            sys_rst_req,
  input logic            ovf,
  input logic [WD_W-1:0] wd_cnt
);
  // R3
  irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_req);

  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);

  // R4
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !ovf) |=> !irq_req);

  // R5
  wd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wd_clr) |=> (wd_cnt == WD_W'($past(wd_cnt) + 1'b1)));

  // R6
  wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clr |=> (!sys_rst_req && wd_cnt == '0));

  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  // R8
  wake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !warm_done);

  // R9
  clr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tb_clr || wake_req) && !irq_req) |=> !irq_req);
endmodule

bind bt_wdt_top bt_wdt_chk #(.WD_W(WD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tb_clr     (tb_clr),
  .wd_clr     (wd_clr),
  .irq_ack    (irq_ack),
  .wake_req   (wake_req),
  .irq_req    (irq_req),
  .warm_done  (warm_done),
  .sys_rst_req(sys_rst_req),
  .ovf        (ovf_w),
  .wd_cnt     (wd_cnt_w)
);

// File: tb/bt_wdt_top_tb_top.sv
module bt_wdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned T_CNT_W = 4;
  localparam int unsigned T_WD_W  = 3;

  typedef struct packed {
    logic [1:0] sel;
    logic [15:0] period;
  } vec_t;

  // period = 2^(T_CNT_W + exp) with exps 2,3,4,5
  localparam vec_t VEC [6] = '{
    '{2'd0, 16'd64},  '{2'd1, 16'd128}, '{2'd2, 16'd256},
    '{2'd3, 16'd512}, '{2'd1, 16'd128}, '{2'd0, 16'd64}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] div_sel = '0;
  logic tb_clr = 1'b0, wd_clr = 1'b0, irq_ack = 1'b0, wake_req = 1'b0;
  logic irq_req, warm_done, sys_rst_req;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bt_wdt_top #(
    .CNT_W(T_CNT_W), .WD_W(T_WD_W), .DIV_EXP('{2, 3, 4, 5})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tb_clr(tb_clr),
    .wd_clr(wd_clr), .irq_ack(irq_ack), .wake_req(wake_req),
    .irq_req(irq_req), .warm_done(warm_done), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // clear timebase, prescaler, watchdog and interrupt on one edge
  task automatic clear_all();
    tb_clr = 1'b1; wd_clr = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0; wd_clr = 1'b0; irq_ack = 1'b0;
  endtask

  // checks that sys_rst_req stays low for n sampled cycles
  task automatic quiet_rst(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_req) seen = 1'b1;
    end
    chk(req, seen, 1'b0);
  endtask

  initial begin
    wait_n(3);
    // R10 reset state
    chk("R10 irq", irq_req, 1'b0);
    chk("R10 warm", warm_done, 1'b1);
    chk("R10 rst", sys_rst_req, 1'b0);
    rst_n = 1'b1;

    // R1 and R3: one wrap period per ratio code, walked from the table
    for (int v = 0; v < 6; v++) begin
      div_sel = VEC[v].sel;
      clear_all();
      wait_n(int'(VEC[v].period) - 1);
      chk("R1 before wrap", irq_req, 1'b0);
      wait_n(1);
      chk("R3 irq at wrap", irq_req, 1'b1);
    end

    // R4: the flag stays set, then an acknowledge clears it
    wait_n(20);
    chk("R4 sticky", irq_req, 1'b1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R4 ack", irq_req, 1'b0);

    // R9 and R2: a clear on the wrap edge wins, and the period restarts
    div_sel = 2'd0;
    clear_all();
    wait_n(63);
    tb_clr = 1'b1; @(negedge clk); tb_clr = 1'b0;
    chk("R9 clear beats tick", irq_req, 1'b0);
    wait_n(63);
    chk("R2 no early wrap", irq_req, 1'b0);
    wait_n(1);
    chk("R2 wrap after clear", irq_req, 1'b1);

    // R5 and R7: the 8th wrap fires a one-cycle reset
    clear_all();
    quiet_rst("R5 quiet before 8th wrap", 511);
    wait_n(1);
    chk("R5 reset on 8th wrap", sys_rst_req, 1'b1);
    wait_n(1);
    chk("R7 single pulse", sys_rst_req, 1'b0);

    // R6: a mid-run watchdog clear restarts the count of 8 wraps
    clear_all();
    wait_n(399);
    wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0;
    quiet_rst("R6 quiet after clear", 495);
    wait_n(1);
    chk("R6 reset after 8 more", sys_rst_req, 1'b1);
    // R6: a clear on the firing wrap edge suppresses the pulse
    wait_n(511);
    wd_clr = 1'b1; @(negedge clk); wd_clr = 1'b0;
    chk("R6 clear beats fire", sys_rst_req, 1'b0);
    wait_n(511);
    chk("R6 count restarted", sys_rst_req, 1'b0);
    wait_n(1);
    chk("R6 fire after restart", sys_rst_req, 1'b1);

    // R8: a wakeup mid-count restarts timing and holds warm_done low
    div_sel = 2'd3;
    clear_all();
    wait_n(100);
    chk("R8 warm before wake", warm_done, 1'b1);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    chk("R8 warm drops", warm_done, 1'b0);
    wait_n(511);
    chk("R8 still warming", warm_done, 1'b0);
    chk("R8 counter cleared by wake", irq_req, 1'b0);
    wait_n(1);
    chk("R8 warm done at wrap", warm_done, 1'b1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL timeout R1..: bench did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end
endmodule